// File: doc/BRIEF.md
# Card Command and Response Sequencer

This block issues one command at a time to a memory card and collects the card's reply for the processor. Software programs a 6-bit command index and a 32-bit argument, which is written as two 16-bit halves. It then writes a command configuration word. That word selects the expected reply type, whether a data phase follows, and whether the command is held back. A command is issued as soon as the configuration word is written if the card clock is already running. Otherwise it waits in a pending latch until software starts the clock.

The command goes to the card side over a valid/ready handshake. `cmd_valid` stays high, with a stable index, until `cmd_ready` is seen high on a clock edge. The reply comes back as a byte stream. A byte is taken on each edge where `rsp_byte_valid` and `rsp_byte_ready` are both high. The block raises `rsp_byte_ready` only while it is collecting a reply, and that is the only back-pressure it applies. Bytes offered at other times are not taken. A `rsp_done` beat ends the reply. A byte presented in the same beat as `rsp_done` is counted.

Bytes are packed in pairs into a nine-entry, 16-bit reply buffer. The reply length is checked against the minimum for the programmed reply type. A short reply sets the timeout flag. A good reply sets the reply-done flag and, when the data phase is enabled, emits a one-cycle `data_go` pulse.

Top module: `cmdseq_top`

## Requirements
- R1: A write to select 0 keeps bits 5:0 as the command index. The 8-bit readback `idx_rd` shows that index with bit 6 forced to 1 and bit 7 at 0.
- R2: A write to select 1 replaces only bits 31:16 of the argument. A write to select 2 replaces only bits 15:0.
- R3: A write to select 3 stores the data ANDed with 14'h3dff, sets the pending latch and aborts any command in progress. The command launches on that write when bit 10 (hold) of the written value is 0 and the clock is enabled. Bits 1:0 hold the reply type and bit 2 enables the data phase.
- R4: A write to select 4 with bit 1 set enables the clock. It also launches the command if one is pending, the stored hold bit is 0 and the block is idle. Bit 0 set disables the clock and aborts any command; it wins over bit 1 in the same write. A launch clears the pending latch.
- R5: Reply type 0 needs no bytes. Types 1 and 3 need at least 4 bytes. Type 2 needs at least 16 bytes. A shorter reply sets `stat_timeout` and ends the command.
- R6: Every launch sets `end_cmd_irq` and clears both status flags. A configuration write that does not launch clears `end_cmd_irq`. A good reply sets `stat_endres`.
- R7: Reply byte n is written to entry n/2. Even-numbered bytes go in bits 15:8 and odd-numbered bytes in bits 7:0. Bytes past the 18th are accepted but dropped.
- R8: A launch zeroes all nine entries and rewinds the read pointer. `rsp_rdata` shows the current entry, and `rsp_rd` advances to the next one. Once nine entries have been read, `rsp_rdata` reads 0.
- R9: A good reply with the data-phase bit set produces a single-cycle `data_go` pulse. Without that bit, no pulse is produced.
- R10: `cmd_valid` stays high with a stable `cmd_index` until `cmd_ready` is taken.
- R11: A clock start while a command is in progress does not relaunch it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 index, 1 arg high, 2 arg low, 3 config, 4 clock control) |
| reg_wdata | input | 16 | Register write data |
| idx_rd | output | 8 | Index readback with bit 6 set |
| arg_rd | output | 32 | Argument readback |
| cfg_rd | output | 14 | Configuration readback |
| clk_en | output | 1 | Card clock enabled |
| busy | output | 1 | A command is in progress |
| stat_timeout | output | 1 | Reply was too short |
| stat_endres | output | 1 | Reply accepted |
| end_cmd_irq | output | 1 | Command launched interrupt |
| data_go | output | 1 | Data phase start pulse |
| cmd_valid | output | 1 | Command offered to card side |
| cmd_ready | input | 1 | Card side takes command |
| cmd_index | output | 6 | Command index to card side |
| cmd_arg | output | 32 | Command argument to card side |
| rsp_byte_valid | input | 1 | Reply byte valid |
| rsp_byte_ready | output | 1 | Block accepts reply bytes |
| rsp_byte | input | 8 | Reply byte |
| rsp_done | input | 1 | End of reply |
| rsp_rd | input | 1 | Advance reply buffer read pointer |
| rsp_rdata | output | 16 | Current reply buffer entry, 0 past the end |

## Verification
The bench hits each reply type exactly at its minimum length and one byte short of it. A wrong threshold would report a timeout on a good reply, or accept a short one. It also sends a final byte in the same beat as `rsp_done`. A design that ignored that byte would time out on a reply that meets the minimum.

It starts the clock a second time after a command has completed. A pending latch that is never cleared would issue the command twice. It also starts the clock while a command is being collected. A relaunch there would show up as `cmd_valid` going high again.

It checks that a launch with no reply leaves the buffer reading zeros, and that reads past the ninth entry return zero. A buffer that is not cleared, or whose pointer wraps, would return stale data. Finally, it sends an overlong reply and sets the hold bit, which exposes byte packing that spills past entry 8 and a hold bit that is ignored.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_COLLECT} seq_state_t;

  localparam logic [2:0] SEL_IDX  = 3'd0;
  localparam logic [2:0] SEL_ARGH = 3'd1;
  localparam logic [2:0] SEL_ARGL = 3'd2;
  localparam logic [2:0] SEL_CFG  = 3'd3;
  localparam logic [2:0] SEL_CLK  = 3'd4;

  localparam int CFG_HOLD_BIT = 10;
  localparam int CFG_DATA_BIT = 2;
endpackage

// File: rtl/cmdseq_regs.sv
module cmdseq_regs
  import cmdseq_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int CFG_W = 14,
  parameter logic [CFG_W-1:0] CFG_MASK = 14'h3dff
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_sel,
  input  logic [ARG_W/2-1:0]   reg_wdata,
  input  logic                 launch,
  output logic [IDX_W-1:0]     idx_q,
  output logic [ARG_W-1:0]     arg_q,
  output logic [CFG_W-1:0]     cfg_q,
  output logic                 clk_en_q,
  output logic                 pending_q,
  output logic                 cfg_wr,
  output logic                 clk_start,
  output logic                 clk_stop
);
  localparam int HALF_W = ARG_W / 2;

  assign cfg_wr    = reg_wr && (reg_sel == SEL_CFG);
  assign clk_start = reg_wr && (reg_sel == SEL_CLK) && reg_wdata[1];
  assign clk_stop  = reg_wr && (reg_sel == SEL_CLK) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      arg_q     <= '0;
      cfg_q     <= '0;
      clk_en_q  <= 1'b0;
      pending_q <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == SEL_IDX)  idx_q <= reg_wdata[IDX_W-1:0];
      if (reg_wr && reg_sel == SEL_ARGH) arg_q[ARG_W-1:HALF_W] <= reg_wdata;
      if (reg_wr && reg_sel == SEL_ARGL) arg_q[HALF_W-1:0] <= reg_wdata;
      if (cfg_wr) cfg_q <= reg_wdata[CFG_W-1:0] & CFG_MASK;
      if (clk_stop)       clk_en_q <= 1'b0;
      else if (clk_start) clk_en_q <= 1'b1;
      if (launch)      pending_q <= 1'b0;
      else if (cfg_wr) pending_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
  import cmdseq_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int MAX_BYTES = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             new_hold,
  input  logic             clk_en_q,
  input  logic             clk_start,
  input  logic             clk_stop,
  input  logic             pending_q,
  input  logic             cfg_hold,
  input  logic [1:0]       rsp_type,
  input  logic             data_en,
  input  logic             cmd_ready,
  input  logic             byte_valid,
  input  logic             done,
  output logic             launch,
  output logic             busy,
  output logic             cmd_valid,
  output logic             byte_ready,
  output logic             byte_we,
  output logic [CNT_W-1:0] byte_idx,
  output logic             stat_timeout,
  output logic             stat_endres,
  output logic             end_cmd_irq,
  output logic             data_go
);
  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] need;
  logic             launch_wr, launch_clk, abort, room, fin, issued;

  function automatic logic [CNT_W-1:0] min_len(input logic [1:0] t);
    case (t)
      2'd0:    min_len = '0;
      2'd2:    min_len = CNT_W'(16);
      default: min_len = CNT_W'(4);
    endcase
  endfunction

  assign launch_wr  = cfg_wr && !new_hold && clk_en_q;
  assign launch_clk = clk_start && !clk_stop && pending_q && !cfg_hold &&
                      (state == ST_IDLE);
  assign launch     = launch_wr || launch_clk;
  assign abort      = cfg_wr || clk_stop;

  assign busy       = (state != ST_IDLE);
  assign cmd_valid  = (state == ST_ISSUE);
  assign byte_ready = (state == ST_COLLECT);
  assign room       = (cnt < CNT_W'(MAX_BYTES));
  assign byte_we    = byte_valid && byte_ready && room;
  assign byte_idx   = cnt;
  assign total      = cnt + (byte_we ? CNT_W'(1) : CNT_W'(0));
  assign need       = min_len(rsp_type);
  assign fin        = done && (state == ST_COLLECT) && !abort;
  assign issued     = cmd_ready && (state == ST_ISSUE) && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      stat_timeout <= 1'b0;
      stat_endres  <= 1'b0;
      end_cmd_irq  <= 1'b0;
      data_go      <= 1'b0;
    end else begin
      data_go <= 1'b0;
      if (launch) begin
        state        <= ST_ISSUE;
        cnt          <= '0;
        stat_timeout <= 1'b0;
        stat_endres  <= 1'b0;
        end_cmd_irq  <= 1'b1;
      end else if (abort) begin
        state <= ST_IDLE;
        if (cfg_wr) end_cmd_irq <= 1'b0;
      end else begin
        if (issued) begin
          if (rsp_type == 2'd0) begin
            state       <= ST_IDLE;
            stat_endres <= 1'b1;
            data_go     <= data_en;
          end else begin
            state <= ST_COLLECT;
          end
        end
        if (byte_we) cnt <= cnt + CNT_W'(1);
        if (fin) begin
          state <= ST_IDLE;
          if (total < need) begin
            stat_timeout <= 1'b1;
          end else begin
            stat_endres <= 1'b1;
            data_go     <= data_en;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cmdseq_rspbuf.sv
module cmdseq_rspbuf #(
  parameter int ENTRIES = 9,
  parameter int ENTRY_W = 16,
  parameter int CNT_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               we,
  input  logic [CNT_W-1:0]   widx,
  input  logic [ENTRY_W/2-1:0] wbyte,
  input  logic               rd,
  output logic [ENTRY_W-1:0] rdata
);
  localparam int PTR_W  = $clog2(ENTRIES + 1);
  localparam int SLOT_W = CNT_W - 1;
  localparam int BYTE_W = ENTRY_W / 2;

  logic [ENTRY_W-1:0] mem [ENTRIES];
  logic [PTR_W-1:0]   ptr;
  logic               more;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic hit;
    assign hit = we && (widx[CNT_W-1:1] == SLOT_W'(e));
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        mem[e] <= '0;
      end else if (hit) begin
        if (!widx[0]) mem[e][ENTRY_W-1:BYTE_W] <= wbyte;
        else          mem[e][BYTE_W-1:0]       <= wbyte;
      end
    end
  end

  assign more  = (ptr < PTR_W'(ENTRIES));
  assign rdata = more ? mem[ptr] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  ptr <= '0;
    else if (rd && more) ptr <= ptr + PTR_W'(1);
  end
endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
  import cmdseq_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int ARG_W   = 32,
  parameter int CFG_W   = 14,
  parameter int ENTRIES = 9,
  parameter int ENTRY_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [2:0]           reg_sel,
  input  logic [ARG_W/2-1:0]   reg_wdata,
  output logic [IDX_W+1:0]     idx_rd,
  output logic [ARG_W-1:0]     arg_rd,
  output logic [CFG_W-1:0]     cfg_rd,
  output logic                 clk_en,
  output logic                 busy,
  output logic                 stat_timeout,
  output logic                 stat_endres,
  output logic                 end_cmd_irq,
  output logic                 data_go,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [IDX_W-1:0]     cmd_index,
  output logic [ARG_W-1:0]     cmd_arg,
  input  logic                 rsp_byte_valid,
  output logic                 rsp_byte_ready,
  input  logic [ENTRY_W/2-1:0] rsp_byte,
  input  logic                 rsp_done,
  input  logic                 rsp_rd,
  output logic [ENTRY_W-1:0]   rsp_rdata
);
  localparam int MAX_BYTES = 2 * ENTRIES;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);

  logic [IDX_W-1:0] idx_q;
  logic [CFG_W-1:0] cfg_q;
  logic             pending_q, cfg_wr, clk_start, clk_stop, launch, byte_we;
  logic [CNT_W-1:0] byte_idx;

  cmdseq_regs #(.IDX_W(IDX_W), .ARG_W(ARG_W), .CFG_W(CFG_W),
                .CFG_MASK(CFG_W'(14'h3dff))) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .launch(launch), .idx_q(idx_q), .arg_q(arg_rd),
    .cfg_q(cfg_q), .clk_en_q(clk_en), .pending_q(pending_q), .cfg_wr(cfg_wr),
    .clk_start(clk_start), .clk_stop(clk_stop)
  );

  cmdseq_ctrl #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .new_hold(reg_wdata[CFG_HOLD_BIT]), .clk_en_q(clk_en),
    .clk_start(clk_start), .clk_stop(clk_stop), .pending_q(pending_q),
    .cfg_hold(cfg_q[CFG_HOLD_BIT]), .rsp_type(cfg_q[1:0]),
    .data_en(cfg_q[CFG_DATA_BIT]), .cmd_ready(cmd_ready),
    .byte_valid(rsp_byte_valid), .done(rsp_done), .launch(launch),
    .busy(busy), .cmd_valid(cmd_valid), .byte_ready(rsp_byte_ready),
    .byte_we(byte_we), .byte_idx(byte_idx), .stat_timeout(stat_timeout),
    .stat_endres(stat_endres), .end_cmd_irq(end_cmd_irq), .data_go(data_go)
  );

  cmdseq_rspbuf #(.ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(launch), .we(byte_we), .widx(byte_idx),
    .wbyte(rsp_byte), .rd(rsp_rd), .rdata(rsp_rdata)
  );

  assign idx_rd    = {1'b0, 1'b1, idx_q};
  assign cfg_rd    = cfg_q;
  assign cmd_index = idx_q;
  assign cmd_arg   = arg_rd;
endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        busy,
  input logic        clk_en,
  input logic        end_cmd_irq,
  input logic        stat_timeout,
  input logic        stat_endres,
  input logic        data_go,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [5:0]  cmd_index,
  input logic        rsp_byte_ready,
  input logic [15:0] rsp_rdata
);
  a_r3_launch_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> clk_en);
  a_r6_launch_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> end_cmd_irq);
  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_timeout && stat_endres));
  a_r8_cleared_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rsp_rdata == 16'h0));
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !reg_wr) |=> (cmd_valid && $stable(cmd_index)));
  a_r9_go_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    data_go |-> (stat_endres && !busy));
  a_r7_ready_only_collecting: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_byte_ready |-> (busy && !cmd_valid));
endmodule

bind cmdseq_top cmdseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .busy(busy), .clk_en(clk_en),
  .end_cmd_irq(end_cmd_irq), .stat_timeout(stat_timeout),
  .stat_endres(stat_endres), .data_go(data_go), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_index(cmd_index),
  .rsp_byte_ready(rsp_byte_ready), .rsp_rdata(rsp_rdata)
);

// File: tb/cmdseq_top_tb_top.sv
`timescale 1ns/1ps
module cmdseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic        cmd_ready = 1'b0;
  logic        rsp_byte_valid = 1'b0;
  logic [7:0]  rsp_byte = 8'h0;
  logic        rsp_done = 1'b0;
  logic        rsp_rd = 1'b0;
  logic [7:0]  idx_rd;
  logic [31:0] arg_rd, cmd_arg;
  logic [13:0] cfg_rd;
  logic        clk_en, busy, stat_timeout, stat_endres, end_cmd_irq, data_go;
  logic        cmd_valid, rsp_byte_ready;
  logic [5:0]  cmd_index;
  logic [15:0] rsp_rdata;
  int          n_checks = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  cmdseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .idx_rd(idx_rd), .arg_rd(arg_rd), .cfg_rd(cfg_rd),
    .clk_en(clk_en), .busy(busy), .stat_timeout(stat_timeout),
    .stat_endres(stat_endres), .end_cmd_irq(end_cmd_irq), .data_go(data_go),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .rsp_byte_valid(rsp_byte_valid),
    .rsp_byte_ready(rsp_byte_ready), .rsp_byte(rsp_byte), .rsp_done(rsp_done),
    .rsp_rd(rsp_rd), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic take_cmd();
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input logic with_done);
    rsp_byte_valid = 1'b1; rsp_byte = b; rsp_done = with_done;
    @(negedge clk);
    rsp_byte_valid = 1'b0; rsp_done = 1'b0;
  endtask

  task automatic end_rsp();
    rsp_done = 1'b1;
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] exp);
    chk(req, {16'h0, rsp_rdata}, {16'h0, exp});
    rsp_rd = 1'b1;
    @(negedge clk);
    rsp_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset idx", {24'h0, idx_rd}, 32'h40);
    chk("R4 reset clk", {31'h0, clk_en}, 32'h0);
    chk("R4 reset busy", {31'h0, busy}, 32'h0);
    chk("R8 reset rdata", {16'h0, rsp_rdata}, 32'h0);
  endtask

  task automatic t_index_arg();
    wr(3'd0, 16'h00FF);
    chk("R1 index masked", {24'h0, idx_rd}, 32'h7F);
    wr(3'd1, 16'h1234);
    wr(3'd2, 16'hABCD);
    chk("R2 arg both", arg_rd, 32'h1234ABCD);
    wr(3'd1, 16'h5555);
    chk("R2 arg high only", arg_rd, 32'h5555ABCD);
    wr(3'd0, 16'h0011);
  endtask

  task automatic t_cfg_mask();
    wr(3'd3, 16'hFFFF);
    chk("R3 cfg mask", {18'h0, cfg_rd}, 32'h3DFF);
    chk("R3 no launch clock off", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_clock_launch();
    wr(3'd3, 16'h0001);
    chk("R3 pending no launch", {31'h0, busy}, 32'h0);
    chk("R6 irq cleared", {31'h0, end_cmd_irq}, 32'h0);
    wr(3'd4, 16'h0002);
    chk("R4 start launches", {31'h0, cmd_valid}, 32'h1);
    chk("R6 irq on launch", {31'h0, end_cmd_irq}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 valid held", {31'h0, cmd_valid}, 32'h1);
      chk("R10 index stable", {26'h0, cmd_index}, 32'h11);
    end
    take_cmd();
    chk("R7 collecting", {31'h0, rsp_byte_ready}, 32'h1);
    wr(3'd4, 16'h0002);
    chk("R11 no relaunch", {31'h0, cmd_valid}, 32'h0);
    chk("R11 still collecting", {31'h0, rsp_byte_ready}, 32'h1);
    put_byte(8'h11, 1'b0); put_byte(8'h22, 1'b0);
    put_byte(8'h33, 1'b0); put_byte(8'h44, 1'b0);
    end_rsp();
    chk("R5 good type1", {30'h0, stat_timeout, stat_endres}, 32'h1);
    chk("R9 no go without data bit", {31'h0, data_go}, 32'h0);
    chk("R4 idle after", {31'h0, busy}, 32'h0);
    rd_chk("R7 entry0", 16'h1122);
    rd_chk("R7 entry1", 16'h3344);
    for (int i = 2; i < 9; i++) rd_chk("R8 tail zero", 16'h0);
    rd_chk("R8 past end", 16'h0);
    rd_chk("R8 past end again", 16'h0);
    wr(3'd4, 16'h0002);
    chk("R4 pending cleared", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_short_type1();
    wr(3'd3, 16'h0001);
    chk("R3 immediate launch", {31'h0, cmd_valid}, 32'h1);
    take_cmd();
    put_byte(8'h01, 1'b0); put_byte(8'h02, 1'b0); put_byte(8'h03, 1'b0);
    end_rsp();
    chk("R5 short type1 timeout", {30'h0, stat_timeout, stat_endres}, 32'h2);
  endtask

  task automatic t_type2(input int nbytes);
    wr(3'd3, 16'h0002);
    chk("R6 status cleared on launch", {30'h0, stat_timeout, stat_endres}, 32'h0);
    take_cmd();
    for (int i = 0; i < nbytes; i++) put_byte(8'hA0 + 8'(i), 1'b0);
    end_rsp();
    if (nbytes < 16) begin
      chk("R5 type2 short", {30'h0, stat_timeout, stat_endres}, 32'h2);
    end else begin
      chk("R5 type2 ok", {30'h0, stat_timeout, stat_endres}, 32'h1);
      for (int k = 0; k < 8; k++)
        rd_chk("R7 type2 entry", {8'hA0 + 8'(2*k), 8'hA1 + 8'(2*k)});
      rd_chk("R8 type2 entry8 zero", 16'h0);
    end
  endtask

  task automatic t_done_with_byte();
    wr(3'd3, 16'h0003);
    take_cmd();
    put_byte(8'h10, 1'b0); put_byte(8'h20, 1'b0); put_byte(8'h30, 1'b0);
    put_byte(8'h40, 1'b1);
    chk("R5 type3 last byte with done", {30'h0, stat_timeout, stat_endres}, 32'h1);
    rd_chk("R7 type3 entry0", 16'h1020);
    rd_chk("R7 type3 entry1", 16'h3040);
  endtask

  task automatic t_type0();
    wr(3'd3, 16'h0000);
    chk("R6 type0 irq", {31'h0, end_cmd_irq}, 32'h1);
    take_cmd();
    chk("R5 type0 no bytes", {30'h0, stat_timeout, stat_endres}, 32'h1);
    chk("R5 type0 idle", {31'h0, busy}, 32'h0);
    rd_chk("R8 cleared by launch", 16'h0);
  endtask

  task automatic t_data_go();
    wr(3'd3, 16'h0005);
    take_cmd();
    for (int i = 0; i < 4; i++) put_byte(8'h50 + 8'(i), 1'b0);
    end_rsp();
    chk("R9 go pulse", {31'h0, data_go}, 32'h1);
    @(negedge clk);
    chk("R9 go single cycle", {31'h0, data_go}, 32'h0);
  endtask

  task automatic t_hold();
    wr(3'd3, 16'h0401);
    chk("R3 hold blocks launch", {31'h0, busy}, 32'h0);
    wr(3'd4, 16'h0002);
    chk("R4 hold blocks start", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_overflow();
    wr(3'd3, 16'h0001);
    take_cmd();
    for (int i = 0; i < 20; i++) put_byte(8'(i), 1'b0);
    end_rsp();
    chk("R5 long ok", {30'h0, stat_timeout, stat_endres}, 32'h1);
    for (int k = 0; k < 9; k++) rd_chk("R7 long entry", {8'(2*k), 8'(2*k+1)});
    rd_chk("R8 long past end", 16'h0);
  endtask

  task automatic t_abort();
    wr(3'd3, 16'h0001);
    take_cmd();
    wr(3'd4, 16'h0003);
    chk("R4 stop aborts", {31'h0, busy}, 32'h0);
    chk("R4 stop wins", {31'h0, clk_en}, 32'h0);
    chk("R7 no ready idle", {31'h0, rsp_byte_ready}, 32'h0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index_arg();
    t_cfg_mask();
    t_clock_launch();
    t_short_type1();
    t_type2(15);
    t_type2(16);
    t_done_with_byte();
    t_type0();
    t_data_go();
    t_overflow();
    t_hold();
    wr(3'd3, 16'h0000);
    t_abort();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule